// File: doc/BRIEF.md
# BCD Calendar Counter with Century

This block is a time-of-day and calendar counter that advances once for each pulse on a one-per-second tick input. It holds seconds, minutes, hours (24-hour), a day-of-week index, day of month, month, year and century. Every field is kept and presented in two-digit packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. Month lengths are derived from the month and year fields, and February takes a leap day under a plain divide-by-four year rule, which is correct through 2099.

Software or a neighbouring block sets the time with a single-cycle parallel load of all eight fields. A stop input freezes all counting. A frequency-test input makes the least significant bit of the seconds output flip on every 512 Hz tick, so that the counting clock can be measured at the seconds output. Values loaded outside the legal ranges give undefined results; the block does not check them.

Top module: `bcd_calendar`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. A second tick sampled at a rising clock edge advances seconds on that edge. Seconds 59 wraps to 00 and advances minutes, and minutes 59 wraps to 00 and advances hours.
- R2: Hours count in BCD from 00 to 23. A tick at 23:59:59 gives 00:00:00 (midnight).
- R3: The day-of-week field advances by one at midnight only, and 07 wraps to 01.
- R4: Day of month starts at 01. It wraps to 01 and advances the month after day 31 in months 01, 03, 05, 07, 08, 10 and 12, and after day 30 in months 04, 06, 09 and 11.
- R5: In month 02 the last day is 29 when the year value is divisible by 4 (00, 04, ..., 96) and 28 otherwise.
- R6: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and advances the century in BCD. Century 39 wraps to 00.
- R7: While the stop input is 1, second ticks change no field.
- R8: With the test input at 1 and the stop input at 0, bit 0 of the seconds output inverts on each clock edge that samples a 512 Hz tick. With the test input at 0, bit 0 shows the counted seconds value. While the stop input is 1 the toggle holds.
- R9: A load strobe writes all eight load inputs into the fields on the next edge. It overrides a second tick in the same cycle and clears the test toggle.
- R10: After reset the outputs read 00:00:00, day-of-week 01, date 01, month 01, year 00, century 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick_i | input | 1 | One-cycle pulse, once per second |
| tick512_i | input | 1 | One-cycle pulse at 512 Hz |
| load_i | input | 1 | Parallel load strobe |
| load_sec_i | input | 8 | BCD seconds to load |
| load_min_i | input | 8 | BCD minutes to load |
| load_hour_i | input | 8 | BCD hours to load |
| load_dow_i | input | 8 | BCD day-of-week to load |
| load_date_i | input | 8 | BCD day of month to load |
| load_month_i | input | 8 | BCD month to load |
| load_year_i | input | 8 | BCD year to load |
| load_cent_i | input | 8 | BCD century to load |
| osc_stop_i | input | 1 | 1 halts counting |
| freq_test_i | input | 1 | 1 enables the 512 Hz toggle on the seconds LSB |
| sec_o | output | 8 | BCD seconds (bit 0 carries the test toggle) |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | BCD hours |
| dow_o | output | 8 | BCD day-of-week |
| date_o | output | 8 | BCD day of month |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |
| cent_o | output | 8 | BCD century |

## Verification
Assertions check the following on every cycle: each field takes its loaded value after a strobe, holds when it gets no carry, and falls back to its lowest value when it wraps. They also check that a stop freezes all fields, that a tick at the end of the day lands on midnight, and that the test toggle flips and clears as required. Only the bench scenarios can show that the carries run in the right order across the calendar. This covers month lengths, the leap-year rule for February, the year and century rollover, and the exact value seen on the seconds LSB under the test toggle. The bench compares all outputs against a binary reference model after every cycle.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int BCD_W  = 8;
  localparam int NFIELD = 8;

  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_DOW   = 3;
  localparam int F_DATE  = 4;
  localparam int F_MONTH = 5;
  localparam int F_YEAR  = 6;
  localparam int F_CENT  = 7;

  typedef logic [BCD_W-1:0] bcd_t;

  // lowest legal value per field (also the reset and wrap target)
  localparam bcd_t FIELD_LO [NFIELD] = '{8'h00, 8'h00, 8'h00, 8'h01,
                                         8'h01, 8'h01, 8'h00, 8'h00};
  // highest value per field (date uses a computed limit instead)
  localparam bcd_t FIELD_HI [NFIELD] = '{8'h59, 8'h59, 8'h23, 8'h07,
                                         8'h31, 8'h12, 8'h99, 8'h39};

  function automatic bcd_t bcd_inc(bcd_t v);
    bcd_t r;
    if (v[3:0] == 4'h9) r = {v[7:4] + 4'h1, 4'h0};
    else                r = {v[7:4], v[3:0] + 4'h1};
    return r;
  endfunction

  // year divisible by 4 <=> (2*tens + units) divisible by 4
  function automatic logic leap_year(bcd_t yr);
    logic [4:0] s;
    s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic bcd_t last_day(bcd_t mon, bcd_t yr);
    bcd_t r;
    case (mon)
      8'h02:                      r = leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bcd_field_cnt.sv
module bcd_field_cnt
  import cal_pkg::*;
#(
  parameter bcd_t LO = 8'h00
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  bcd_t load_val_i,
  input  logic inc_i,
  input  bcd_t hi_i,
  output bcd_t val_o,
  output logic wrap_o
);
  bcd_t val_q, val_d;
  logic en;
  logic at_top;

  assign at_top = (val_q >= hi_i);

  always_comb begin
    en    = load_i | inc_i;
    val_d = val_q;
    if (load_i)     val_d = load_val_i;
    else if (inc_i) val_d = at_top ? LO : bcd_inc(val_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  val_q <= LO;
    else if (en) val_q <= val_d;
  end

  assign val_o  = val_q;
  assign wrap_o = inc_i & at_top & ~load_i;

  // R9: a strobe stores the load value
  p_load_takes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (val_q == $past(load_val_i)));
  // R1: a wrapping field returns to its lowest value
  p_wrap_to_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && at_top) |=> (val_q == LO));
  // R7: without carry or load the field holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !load_i) |=> $stable(val_q));
endmodule

// File: rtl/test_toggle.sv
module test_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  input  logic tick_i,
  output logic phase_o
);
  logic phase_q, phase_d, upd;

  always_comb begin
    upd     = clr_i | (en_i & tick_i);
    phase_d = clr_i ? 1'b0 : ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase_q <= 1'b0;
    else if (upd) phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  // R8: each sampled 512 Hz tick inverts the phase
  p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && !clr_i) |=> (phase_q != $past(phase_q)));
  // R9: clearing leaves the phase at 0
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !phase_q);
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick_i,
  input  logic       tick512_i,
  input  logic       load_i,
  input  logic [7:0] load_sec_i,
  input  logic [7:0] load_min_i,
  input  logic [7:0] load_hour_i,
  input  logic [7:0] load_dow_i,
  input  logic [7:0] load_date_i,
  input  logic [7:0] load_month_i,
  input  logic [7:0] load_year_i,
  input  logic [7:0] load_cent_i,
  input  logic       osc_stop_i,
  input  logic       freq_test_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic [7:0] cent_o
);
  logic [NFIELD-1:0][BCD_W-1:0] ld_val, fld_q, hi_lim;
  logic [NFIELD-1:0]            carry, wrap;
  logic                         advance, phase;

  assign advance = sec_tick_i & ~osc_stop_i & ~load_i;

  always_comb begin
    ld_val[F_SEC]   = load_sec_i;
    ld_val[F_MIN]   = load_min_i;
    ld_val[F_HOUR]  = load_hour_i;
    ld_val[F_DOW]   = load_dow_i;
    ld_val[F_DATE]  = load_date_i;
    ld_val[F_MONTH] = load_month_i;
    ld_val[F_YEAR]  = load_year_i;
    ld_val[F_CENT]  = load_cent_i;
  end

  // carry order: the day-of-week and the date both follow the hour wrap
  always_comb begin
    carry[F_SEC]   = advance;
    carry[F_MIN]   = wrap[F_SEC];
    carry[F_HOUR]  = wrap[F_MIN];
    carry[F_DOW]   = wrap[F_HOUR];
    carry[F_DATE]  = wrap[F_HOUR];
    carry[F_MONTH] = wrap[F_DATE];
    carry[F_YEAR]  = wrap[F_MONTH];
    carry[F_CENT]  = wrap[F_YEAR];
  end

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    if (i == F_DATE) begin : g_dyn
      assign hi_lim[i] = last_day(fld_q[F_MONTH], fld_q[F_YEAR]);
    end else begin : g_fix
      assign hi_lim[i] = FIELD_HI[i];
    end
    bcd_field_cnt #(.LO(FIELD_LO[i])) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load_i),
      .load_val_i(ld_val[i]),
      .inc_i     (carry[i]),
      .hi_i      (hi_lim[i]),
      .val_o     (fld_q[i]),
      .wrap_o    (wrap[i])
    );
  end

  test_toggle u_toggle (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (load_i | ~freq_test_i),
    .en_i   (~osc_stop_i),
    .tick_i (tick512_i),
    .phase_o(phase)
  );

  assign sec_o   = {fld_q[F_SEC][7:1], fld_q[F_SEC][0] ^ phase};
  assign min_o   = fld_q[F_MIN];
  assign hour_o  = fld_q[F_HOUR];
  assign dow_o   = fld_q[F_DOW];
  assign date_o  = fld_q[F_DATE];
  assign month_o = fld_q[F_MONTH];
  assign year_o  = fld_q[F_YEAR];
  assign cent_o  = fld_q[F_CENT];

  // R7: a stopped oscillator freezes every field
  p_stop_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stop_i && !load_i) |=> $stable(fld_q));
  // R2: the last tick of the day lands on midnight
  p_midnight_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && fld_q[F_SEC] == 8'h59 && fld_q[F_MIN] == 8'h59 &&
     fld_q[F_HOUR] == 8'h23)
    |=> (fld_q[F_HOUR] == 8'h00 && fld_q[F_MIN] == 8'h00 &&
         fld_q[F_SEC] == 8'h00));
  // R8: without test mode the seconds output is the counted value
  p_no_test_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!freq_test_i) |-> (sec_o == fld_q[F_SEC]));
endmodule

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
  localparam time CLK_P = 5ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick_i = 1'b0, tick512_i = 1'b0, load_i = 1'b0;
  logic osc_stop_i = 1'b0, freq_test_i = 1'b0;
  logic [7:0] load_sec_i = '0, load_min_i = '0, load_hour_i = '0, load_dow_i = '0;
  logic [7:0] load_date_i = '0, load_month_i = '0, load_year_i = '0, load_cent_i = '0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o, cent_o;

  int n_vec = 0, n_bad = 0;
  // binary reference state
  int m_s = 0, m_mi = 0, m_h = 0, m_dw = 1, m_dt = 1, m_mo = 1, m_yr = 0, m_ce = 0;
  bit m_ph = 0;

  always #(CLK_P/2) clk = ~clk;

  bcd_calendar u_bcd_calendar (.*);

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_edge();
    if (load_i) begin
      m_s  = int'(load_sec_i[7:4])*10 + int'(load_sec_i[3:0]);
      m_mi = int'(load_min_i[7:4])*10 + int'(load_min_i[3:0]);
      m_h  = int'(load_hour_i[7:4])*10 + int'(load_hour_i[3:0]);
      m_dw = int'(load_dow_i[7:4])*10 + int'(load_dow_i[3:0]);
      m_dt = int'(load_date_i[7:4])*10 + int'(load_date_i[3:0]);
      m_mo = int'(load_month_i[7:4])*10 + int'(load_month_i[3:0]);
      m_yr = int'(load_year_i[7:4])*10 + int'(load_year_i[3:0]);
      m_ce = int'(load_cent_i[7:4])*10 + int'(load_cent_i[3:0]);
    end else if (sec_tick_i && !osc_stop_i) begin
      m_s++;
      if (m_s == 60) begin
        m_s = 0; m_mi++;
        if (m_mi == 60) begin
          m_mi = 0; m_h++;
          if (m_h == 24) begin
            m_h = 0;
            m_dw = (m_dw == 7) ? 1 : m_dw + 1;
            m_dt++;
            if (m_dt > mdays(m_mo, m_yr)) begin
              m_dt = 1; m_mo++;
              if (m_mo == 13) begin
                m_mo = 1; m_yr++;
                if (m_yr == 100) begin
                  m_yr = 0;
                  m_ce = (m_ce == 39) ? 0 : m_ce + 1;
                end
              end
            end
          end
        end
      end
    end
    if (load_i || !freq_test_i) m_ph = 0;
    else if (tick512_i && !osc_stop_i) m_ph = ~m_ph;
  endtask

  task automatic cmp(string tag, string fname, logic [7:0] got, logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %02h expected %02h at %0t", tag, fname, got, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    logic [7:0] es;
    es = to_bcd(m_s);
    es[0] = es[0] ^ m_ph;
    cmp(tag, "sec", sec_o, es);
    cmp(tag, "min", min_o, to_bcd(m_mi));
    cmp(tag, "hour", hour_o, to_bcd(m_h));
    cmp(tag, "dow", dow_o, to_bcd(m_dw));
    cmp(tag, "date", date_o, to_bcd(m_dt));
    cmp(tag, "month", month_o, to_bcd(m_mo));
    cmp(tag, "year", year_o, to_bcd(m_yr));
    cmp(tag, "cent", cent_o, to_bcd(m_ce));
  endtask

  // one clock: inputs already driven; sample 1 ns after the edge
  task automatic cyc(string tag);
    @(posedge clk);
    model_edge();
    #1ns;
    check_all(tag);
  endtask

  task automatic do_load(int s, int mi, int h, int dw, int dt, int mo, int yr, int ce,
                         bit tick, string tag);
    load_sec_i = to_bcd(s);  load_min_i = to_bcd(mi); load_hour_i = to_bcd(h);
    load_dow_i = to_bcd(dw); load_date_i = to_bcd(dt); load_month_i = to_bcd(mo);
    load_year_i = to_bcd(yr); load_cent_i = to_bcd(ce);
    load_i = 1'b1; sec_tick_i = tick;
    cyc(tag);
    load_i = 1'b0; sec_tick_i = 1'b0;
  endtask

  task automatic tick(string tag);
    sec_tick_i = 1'b1;
    cyc(tag);
    sec_tick_i = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1743));
    #(CLK_P * 3 + 1ns);
    check_all("R10");                  // outputs during reset
    rst_n = 1'b1;
    cyc("R10");

    // R1: simple second steps and minute carry
    do_load(58, 10, 5, 3, 15, 6, 24, 20, 1'b0, "R9");
    tick("R1"); tick("R1"); tick("R1");
    // R2/R3: midnight, day-of-week 7 wraps to 1
    do_load(59, 59, 23, 7, 10, 3, 41, 20, 1'b0, "R9");
    tick("R2"); tick("R3");
    // R3: midnight with day-of-week 3
    do_load(59, 59, 23, 3, 10, 3, 41, 20, 1'b0, "R9");
    tick("R3");
    // R4: 30-day and 31-day months
    do_load(59, 59, 23, 1, 30, 4, 50, 20, 1'b0, "R9");
    tick("R4");
    do_load(59, 59, 23, 1, 30, 8, 50, 20, 1'b0, "R9");
    tick("R4");
    do_load(59, 59, 23, 1, 31, 8, 50, 20, 1'b0, "R9");
    tick("R4");
    // R5: February, leap and non-leap years
    do_load(59, 59, 23, 2, 28, 2, 23, 20, 1'b0, "R9");
    tick("R5");
    do_load(59, 59, 23, 2, 28, 2, 24, 20, 1'b0, "R9");
    tick("R5");
    do_load(59, 59, 23, 2, 29, 2, 0, 20, 1'b0, "R9");
    tick("R5");
    // R6: year and century rollover, century 39 -> 00
    do_load(59, 59, 23, 5, 31, 12, 99, 19, 1'b0, "R9");
    tick("R6");
    do_load(59, 59, 23, 5, 31, 12, 99, 39, 1'b0, "R9");
    tick("R6");
    // R7: stop freezes counting
    osc_stop_i = 1'b1;
    for (int k = 0; k < 5; k++) tick("R7");
    osc_stop_i = 1'b0;
    tick("R7");
    // R8: test toggle on the seconds LSB
    freq_test_i = 1'b1;
    for (int k = 0; k < 6; k++) begin
      tick512_i = 1'b1; cyc("R8");
      tick512_i = 1'b0; cyc("R8");
    end
    osc_stop_i = 1'b1; tick512_i = 1'b1; cyc("R8"); tick512_i = 1'b0;
    osc_stop_i = 1'b0;
    tick512_i = 1'b1; cyc("R8"); tick512_i = 1'b0;
    // R9: load with a tick in the same cycle; load clears the toggle
    do_load(12, 34, 12, 4, 20, 7, 77, 21, 1'b1, "R9");
    freq_test_i = 1'b0; cyc("R8");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      sec_tick_i  = ($urandom % 4) != 0;
      tick512_i   = ($urandom % 2) == 1;
      osc_stop_i  = ($urandom % 16) == 0;
      freq_test_i = ($urandom % 4) == 0;
      if (($urandom % 64) == 0) begin
        int mo, yr;
        mo = 1 + $urandom % 12;
        yr = $urandom % 100;
        load_i = 1'b1;
        load_sec_i  = to_bcd(50 + $urandom % 10);
        load_min_i  = to_bcd(($urandom % 2) ? 59 : $urandom % 60);
        load_hour_i = to_bcd(($urandom % 2) ? 23 : $urandom % 24);
        load_dow_i  = to_bcd(1 + $urandom % 7);
        load_date_i = to_bcd(mdays(mo, yr) - $urandom % 2);
        load_month_i = to_bcd(($urandom % 3 == 0) ? 12 : mo);
        if (load_month_i == 8'h12) load_date_i = to_bcd(31 - $urandom % 2);
        load_year_i = to_bcd(yr);
        load_cent_i = to_bcd($urandom % 40);
      end
      cyc(load_i ? "R9" : "R1");
      load_i = 1'b0;
    end

    summary();
    $finish;
  end
endmodule